// File: doc/BRIEF.md
# SoC Address Region Decoder

This block sorts every 32-bit bus address into one target of a system memory map. It then drives a chip select for that target and gives the byte offset inside it. The targets are a small internal ROM, a small internal SRAM, six external static-memory banks, two external dynamic-memory ranks and the register/peripheral space. The bottom 128 MB of the map has no memory of its own. It is a boot window, and a two-bit boot-mode input steers it to the ROM, to the SRAM or to static bank 0. Reserved holes in the map select nothing and raise an error flag instead.

The ROM and SRAM decode windows are far larger than the memories behind them. The offset reported for them wraps at the physical size, so the memory repeats through its window. All outputs are registered on the rising clock edge. A result therefore appears one cycle after the address is presented, which lets the block sit on a pipeline stage of an interconnect without adding combinational depth downstream.

Top module: `mmap_addr_decoder`

## Requirements
- R1: An address in 0x0800_0000..0x0BFF_FFFF asserts sel_rom, and offset equals the address modulo 32768 (the ROM image repeats every 32 KB).
- R2: An address in 0x0C00_0000..0x0FFF_FFFF asserts sel_sram, and offset equals the address modulo 8192.
- R3: An address in 0x1000_0000..0x3FFF_FFFF asserts sel_static[n] for n = (address − 0x1000_0000) / 0x0800_0000 (bit n of the vector), with offset equal to the address modulo 0x0800_0000.
- R4: Addresses 0x5000_0000..0x5FFF_FFFF assert sel_dyn[0] and 0x6000_0000..0x6FFF_FFFF assert sel_dyn[1], each with offset equal to the address modulo 0x1000_0000.
- R5: Any address at or above 0x7000_0000 asserts sel_periph, with offset = address − 0x7000_0000.
- R6: An address below 0x0800_0000 is a boot-window access. boot_mode 2'b00 routes it to sel_rom, 2'b01 to sel_sram and 2'b10 to sel_static[0]. via_mirror is set, and the offset follows the wrap rule of the chosen target. Outside the boot window, boot_mode has no effect and via_mirror is 0.
- R7: A boot-window access with boot_mode 2'b11 asserts no select, clears via_mirror, sets dec_err and drives offset 0.
- R8: An address in the reserved range 0x4000_0000..0x4FFF_FFFF asserts no select, sets dec_err and drives offset 0.
- R9: When dec_err is 0 after the first post-reset cycle, exactly one of the eleven select outputs is 1.
- R10: Outputs take the decode of the inputs sampled at a rising edge and hold it until the next edge. While rst is high, at an edge every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 32 | Bus address to classify |
| boot_mode | input | 2 | Boot medium behind the boot window (00 ROM, 01 SRAM, 10 static bank 0, 11 none) |
| sel_rom | output | 1 | Internal ROM select |
| sel_sram | output | 1 | Internal SRAM select |
| sel_static | output | 6 | Static-memory bank selects, bit n for bank n |
| sel_dyn | output | 2 | Dynamic-memory rank selects |
| sel_periph | output | 1 | Peripheral/register space select |
| via_mirror | output | 1 | Access arrived through the boot window |
| dec_err | output | 1 | Address hit a reserved hole or an unbacked boot window |
| offset | output | 32 | Byte offset inside the selected target |

## Verification
The bench probes the first and last byte of each window, where an off-by-one base compare would hand the edge address to a neighbour or to the error path. It hits ROM and SRAM addresses one past the physical size to confirm the offset folds back to zero instead of running past the memory. Each boot mode is driven against the boot window, including the unbacked code, and random boot modes are applied elsewhere to show that a decoder leaking the mode outside the window would misroute. It also checks that outputs still show the old decode just after inputs change, which a combinational (unregistered) path would fail.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_BOOT   = 3'd1,
    K_ROM    = 3'd2,
    K_SRAM   = 3'd3,
    K_STATIC = 3'd4,
    K_DYN    = 3'd5,
    K_PERIPH = 3'd6
  } kind_e;

  localparam logic [1:0] BOOT_FROM_ROM    = 2'b00;
  localparam logic [1:0] BOOT_FROM_SRAM   = 2'b01;
  localparam logic [1:0] BOOT_FROM_STATIC = 2'b10;
endpackage

// File: rtl/mmap_region_classify.sv
module mmap_region_classify
  import mmap_pkg::*;
#(
  parameter addr_t ROM_BASE    = 32'h0800_0000,
  parameter addr_t SRAM_BASE   = 32'h0C00_0000,
  parameter addr_t STATIC_BASE = 32'h1000_0000,
  parameter int    BANK_LG     = 27,
  parameter int    N_STATIC    = 6,
  parameter addr_t DYN_BASE    = 32'h5000_0000,
  parameter int    DYN_LG      = 28,
  parameter int    N_DYN       = 2,
  parameter addr_t PERIPH_BASE = 32'h7000_0000,
  parameter int    SIDX_W      = 3,
  parameter int    DIDX_W      = 1
) (
  input  addr_t              addr,
  output kind_e              kind,
  output logic [SIDX_W-1:0]  st_idx,
  output logic [DIDX_W-1:0]  dy_idx,
  output addr_t              raw_off
);
  localparam addr_t STATIC_END = addr_t'(64'(STATIC_BASE) + (64'(N_STATIC) << BANK_LG));
  localparam addr_t DYN_END    = addr_t'(64'(DYN_BASE) + (64'(N_DYN) << DYN_LG));
  localparam addr_t BANK_MASK  = addr_t'((64'd1 << BANK_LG) - 64'd1);
  localparam addr_t RANK_MASK  = addr_t'((64'd1 << DYN_LG) - 64'd1);

  addr_t st_rel;
  addr_t dy_rel;

  always_comb begin
    st_rel  = addr - STATIC_BASE;
    dy_rel  = addr - DYN_BASE;
    kind    = K_NONE;
    st_idx  = '0;
    dy_idx  = '0;
    raw_off = '0;
    if (addr < ROM_BASE) begin
      kind    = K_BOOT;
      raw_off = addr;
    end else if (addr < SRAM_BASE) begin
      kind    = K_ROM;
      raw_off = addr - ROM_BASE;
    end else if (addr < STATIC_BASE) begin
      kind    = K_SRAM;
      raw_off = addr - SRAM_BASE;
    end else if (addr < STATIC_END) begin
      kind    = K_STATIC;
      st_idx  = st_rel[BANK_LG +: SIDX_W];
      raw_off = st_rel & BANK_MASK;
    end else if (addr < DYN_BASE) begin
      kind    = K_NONE;
    end else if (addr < DYN_END) begin
      kind    = K_DYN;
      dy_idx  = dy_rel[DYN_LG +: DIDX_W];
      raw_off = dy_rel & RANK_MASK;
    end else if (addr >= PERIPH_BASE) begin
      kind    = K_PERIPH;
      raw_off = addr - PERIPH_BASE;
    end
  end
endmodule

// File: rtl/mmap_boot_resolve.sv
module mmap_boot_resolve
  import mmap_pkg::*;
#(
  parameter int ROM_BYTES  = 32768,
  parameter int SRAM_BYTES = 8192,
  parameter int BANK_LG    = 27,
  parameter int SIDX_W     = 3
) (
  input  kind_e              kind_i,
  input  logic [SIDX_W-1:0]  st_idx_i,
  input  addr_t              off_i,
  input  logic [1:0]         boot_mode,
  output kind_e              kind_o,
  output logic [SIDX_W-1:0]  st_idx_o,
  output logic               mirror,
  output addr_t              off_o
);
  localparam addr_t ROM_MASK  = addr_t'(ROM_BYTES - 1);
  localparam addr_t SRAM_MASK = addr_t'(SRAM_BYTES - 1);
  localparam addr_t BANK_MASK = addr_t'((64'd1 << BANK_LG) - 64'd1);

  always_comb begin
    kind_o   = kind_i;
    st_idx_o = st_idx_i;
    mirror   = 1'b0;
    off_o    = off_i;
    if (kind_i == K_BOOT) begin
      mirror = 1'b1;
      case (boot_mode)
        BOOT_FROM_ROM:    kind_o = K_ROM;
        BOOT_FROM_SRAM:   kind_o = K_SRAM;
        BOOT_FROM_STATIC: begin
          kind_o   = K_STATIC;
          st_idx_o = '0;
        end
        default: begin
          kind_o = K_NONE;
          mirror = 1'b0;
        end
      endcase
    end
    case (kind_o)
      K_ROM:    off_o = off_i & ROM_MASK;
      K_SRAM:   off_o = off_i & SRAM_MASK;
      K_STATIC: off_o = off_i & BANK_MASK;
      K_NONE:   off_o = '0;
      default:  off_o = off_i;
    endcase
  end
endmodule

// File: rtl/mmap_sel_reg.sv
module mmap_sel_reg
  import mmap_pkg::*;
#(
  parameter int N_STATIC = 6,
  parameter int N_DYN    = 2,
  parameter int SIDX_W   = 3,
  parameter int DIDX_W   = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  kind_e               kind,
  input  logic [SIDX_W-1:0]   st_idx,
  input  logic [DIDX_W-1:0]   dy_idx,
  input  logic                mirror,
  input  addr_t               off,
  output logic                sel_rom,
  output logic                sel_sram,
  output logic [N_STATIC-1:0] sel_static,
  output logic [N_DYN-1:0]    sel_dyn,
  output logic                sel_periph,
  output logic                via_mirror,
  output logic                dec_err,
  output addr_t               offset
);
  logic [N_STATIC-1:0] st_hot;
  logic [N_DYN-1:0]    dy_hot;

  for (genvar gi = 0; gi < N_STATIC; gi++) begin : g_st
    assign st_hot[gi] = (kind == K_STATIC) && (st_idx == SIDX_W'(gi));
  end
  for (genvar gj = 0; gj < N_DYN; gj++) begin : g_dy
    assign dy_hot[gj] = (kind == K_DYN) && (dy_idx == DIDX_W'(gj));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_rom    <= 1'b0;
      sel_sram   <= 1'b0;
      sel_static <= '0;
      sel_dyn    <= '0;
      sel_periph <= 1'b0;
      via_mirror <= 1'b0;
      dec_err    <= 1'b0;
      offset     <= '0;
    end else begin
      sel_rom    <= (kind == K_ROM);
      sel_sram   <= (kind == K_SRAM);
      sel_static <= st_hot;
      sel_dyn    <= dy_hot;
      sel_periph <= (kind == K_PERIPH);
      via_mirror <= mirror;
      dec_err    <= (kind == K_NONE);
      offset     <= off;
    end
  end
endmodule

// File: rtl/mmap_addr_decoder.sv
module mmap_addr_decoder
  import mmap_pkg::*;
#(
  parameter addr_t ROM_BASE    = 32'h0800_0000,
  parameter addr_t SRAM_BASE   = 32'h0C00_0000,
  parameter addr_t STATIC_BASE = 32'h1000_0000,
  parameter int    BANK_LG     = 27,
  parameter int    N_STATIC    = 6,
  parameter addr_t DYN_BASE    = 32'h5000_0000,
  parameter int    DYN_LG      = 28,
  parameter int    N_DYN       = 2,
  parameter addr_t PERIPH_BASE = 32'h7000_0000,
  parameter int    ROM_BYTES   = 32768,
  parameter int    SRAM_BYTES  = 8192
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [31:0]         addr,
  input  logic [1:0]          boot_mode,
  output logic                sel_rom,
  output logic                sel_sram,
  output logic [N_STATIC-1:0] sel_static,
  output logic [N_DYN-1:0]    sel_dyn,
  output logic                sel_periph,
  output logic                via_mirror,
  output logic                dec_err,
  output logic [31:0]         offset
);
  localparam int SIDX_W = (N_STATIC > 1) ? $clog2(N_STATIC) : 1;
  localparam int DIDX_W = (N_DYN > 1) ? $clog2(N_DYN) : 1;

  kind_e             cls_kind;
  logic [SIDX_W-1:0] cls_st;
  logic [DIDX_W-1:0] cls_dy;
  addr_t             cls_off;
  kind_e             res_kind;
  logic [SIDX_W-1:0] res_st;
  logic              res_mirror;
  addr_t             res_off;

  mmap_region_classify #(
    .ROM_BASE(ROM_BASE), .SRAM_BASE(SRAM_BASE), .STATIC_BASE(STATIC_BASE),
    .BANK_LG(BANK_LG), .N_STATIC(N_STATIC), .DYN_BASE(DYN_BASE),
    .DYN_LG(DYN_LG), .N_DYN(N_DYN), .PERIPH_BASE(PERIPH_BASE),
    .SIDX_W(SIDX_W), .DIDX_W(DIDX_W)
  ) u_classify (
    .addr(addr), .kind(cls_kind), .st_idx(cls_st), .dy_idx(cls_dy), .raw_off(cls_off)
  );

  mmap_boot_resolve #(
    .ROM_BYTES(ROM_BYTES), .SRAM_BYTES(SRAM_BYTES), .BANK_LG(BANK_LG), .SIDX_W(SIDX_W)
  ) u_resolve (
    .kind_i(cls_kind), .st_idx_i(cls_st), .off_i(cls_off), .boot_mode(boot_mode),
    .kind_o(res_kind), .st_idx_o(res_st), .mirror(res_mirror), .off_o(res_off)
  );

  mmap_sel_reg #(
    .N_STATIC(N_STATIC), .N_DYN(N_DYN), .SIDX_W(SIDX_W), .DIDX_W(DIDX_W)
  ) u_sel_reg (
    .clk(clk), .rst(rst), .kind(res_kind), .st_idx(res_st), .dy_idx(cls_dy),
    .mirror(res_mirror), .off(res_off),
    .sel_rom(sel_rom), .sel_sram(sel_sram), .sel_static(sel_static), .sel_dyn(sel_dyn),
    .sel_periph(sel_periph), .via_mirror(via_mirror), .dec_err(dec_err), .offset(offset)
  );
endmodule

// File: rtl/mmap_checker.sv
module mmap_checker #(
  parameter int          N_STATIC    = 6,
  parameter int          N_DYN       = 2,
  parameter int          ROM_BYTES   = 32768,
  parameter int          SRAM_BYTES  = 8192,
  parameter logic [31:0] ROM_BASE    = 32'h0800_0000,
  parameter logic [31:0] RSV_LO      = 32'h4000_0000,
  parameter logic [31:0] RSV_HI      = 32'h5000_0000,
  parameter logic [31:0] DYN_BASE    = 32'h5000_0000,
  parameter int          DYN_LG      = 28
) (
  input logic                clk,
  input logic                rst,
  input logic [31:0]         addr,
  input logic [1:0]          boot_mode,
  input logic                sel_rom,
  input logic                sel_sram,
  input logic [N_STATIC-1:0] sel_static,
  input logic [N_DYN-1:0]    sel_dyn,
  input logic                sel_periph,
  input logic                via_mirror,
  input logic                dec_err,
  input logic [31:0]         offset
);
  localparam logic [31:0] RANK0_END = DYN_BASE + (32'd1 << DYN_LG);

  logic [N_STATIC+N_DYN+2:0] sel_all;
  logic started;

  assign sel_all = {sel_periph, sel_dyn, sel_static, sel_sram, sel_rom};

  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
  end

  a_r9_at_most_one: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_all));

  a_r9_exactly_one: assert property (@(posedge clk) disable iff (rst)
    (started && !dec_err) |-> ($countones(sel_all) == 1));

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
    dec_err |-> (sel_all == '0 && offset == 32'd0 && !via_mirror));

  a_r8_reserved_flags: assert property (@(posedge clk) disable iff (rst)
    (addr >= RSV_LO && addr < RSV_HI) |=> dec_err);

  a_r1_rom_wrap: assert property (@(posedge clk) disable iff (rst)
    sel_rom |-> (offset < 32'(ROM_BYTES)));

  a_r2_sram_wrap: assert property (@(posedge clk) disable iff (rst)
    sel_sram |-> (offset < 32'(SRAM_BYTES)));

  a_r6_mirror_target: assert property (@(posedge clk) disable iff (rst)
    via_mirror |-> (sel_rom || sel_sram || sel_static[0]));

  a_r7_unbacked_boot: assert property (@(posedge clk) disable iff (rst)
    (addr < ROM_BASE && boot_mode == 2'b11) |=> dec_err);

  a_r4_rank0: assert property (@(posedge clk) disable iff (rst)
    (addr >= DYN_BASE && addr < RANK0_END) |=> sel_dyn[0]);
endmodule

bind mmap_addr_decoder mmap_checker #(
  .N_STATIC(N_STATIC), .N_DYN(N_DYN), .ROM_BYTES(ROM_BYTES), .SRAM_BYTES(SRAM_BYTES),
  .ROM_BASE(ROM_BASE), .RSV_LO(32'(64'(STATIC_BASE) + (64'(N_STATIC) << BANK_LG))),
  .RSV_HI(DYN_BASE), .DYN_BASE(DYN_BASE), .DYN_LG(DYN_LG)
) u_mmap_checker (
  .clk(clk), .rst(rst), .addr(addr), .boot_mode(boot_mode),
  .sel_rom(sel_rom), .sel_sram(sel_sram), .sel_static(sel_static), .sel_dyn(sel_dyn),
  .sel_periph(sel_periph), .via_mirror(via_mirror), .dec_err(dec_err), .offset(offset)
);

// File: tb/tb_mmap_addr_decoder.sv
module tb_mmap_addr_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] addr = 32'd0;
  logic [1:0]  boot_mode = 2'b00;
  logic        sel_rom, sel_sram, sel_periph, via_mirror, dec_err;
  logic [5:0]  sel_static;
  logic [1:0]  sel_dyn;
  logic [31:0] offset;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mmap_addr_decoder dut (
    .clk(clk), .rst(rst), .addr(addr), .boot_mode(boot_mode),
    .sel_rom(sel_rom), .sel_sram(sel_sram), .sel_static(sel_static), .sel_dyn(sel_dyn),
    .sel_periph(sel_periph), .via_mirror(via_mirror), .dec_err(dec_err), .offset(offset)
  );

  // select bit layout: [0] rom, [1] sram, [7:2] static, [9:8] dyn, [10] periph
  function automatic logic [10:0] got_sel();
    return {sel_periph, sel_dyn, sel_static, sel_sram, sel_rom};
  endfunction

  function automatic void model(input logic [31:0] a, input logic [1:0] m,
                                output logic [10:0] s, output logic mir,
                                output logic err, output logic [31:0] off);
    s = '0; mir = 1'b0; err = 1'b0; off = 32'd0;
    if (a < 32'h0800_0000) begin
      case (m)
        2'b00: begin s[0] = 1'b1; mir = 1'b1; off = a & 32'h0000_7FFF; end
        2'b01: begin s[1] = 1'b1; mir = 1'b1; off = a & 32'h0000_1FFF; end
        2'b10: begin s[2] = 1'b1; mir = 1'b1; off = a & 32'h07FF_FFFF; end
        default: err = 1'b1;
      endcase
    end else if (a < 32'h0C00_0000) begin
      s[0] = 1'b1; off = a & 32'h0000_7FFF;
    end else if (a < 32'h1000_0000) begin
      s[1] = 1'b1; off = a & 32'h0000_1FFF;
    end else if (a < 32'h4000_0000) begin
      s[2 + ((a - 32'h1000_0000) >> 27)] = 1'b1; off = a & 32'h07FF_FFFF;
    end else if (a < 32'h5000_0000) begin
      err = 1'b1;
    end else if (a < 32'h7000_0000) begin
      s[(a >= 32'h6000_0000) ? 9 : 8] = 1'b1; off = a & 32'h0FFF_FFFF;
    end else begin
      s[10] = 1'b1; off = a - 32'h7000_0000;
    end
  endfunction

  function automatic string req_of(input logic [31:0] a, input logic [1:0] m);
    if (a < 32'h0800_0000) return (m == 2'b11) ? "R7" : "R6";
    if (a < 32'h0C00_0000) return "R1";
    if (a < 32'h1000_0000) return "R2";
    if (a < 32'h4000_0000) return "R3";
    if (a < 32'h5000_0000) return "R8";
    if (a < 32'h7000_0000) return "R4";
    return "R5";
  endfunction

  function automatic logic [44:0] pack_out(input logic [10:0] s, input logic mir,
                                           input logic err, input logic [31:0] off);
    return {s, mir, err, off};
  endfunction

  task automatic compare(input string req, input logic [44:0] got, input logic [44:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s sel/mir/err/off got=%h exp=%h", req, got, exp);
    end
  endtask

  logic [44:0] prev_exp = '0;

  // drive at a falling edge, confirm old output holds, then check one edge later
  task automatic apply(input logic [31:0] a, input logic [1:0] m);
    logic [10:0] s; logic mir, err; logic [31:0] off;
    addr = a; boot_mode = m;
    #1;
    compare("R10", pack_out(got_sel(), via_mirror, dec_err, offset), prev_exp);
    model(a, m, s, mir, err, off);
    @(negedge clk);
    compare(req_of(a, m), pack_out(got_sel(), via_mirror, dec_err, offset),
            pack_out(s, mir, err, off));
    if (!err) begin
      checks++;
      if ($countones(got_sel()) != 1) begin
        failures++;
        $display("FAIL R9 select count got=%0d exp=1", $countones(got_sel()));
      end
    end
    prev_exp = pack_out(s, mir, err, off);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  logic [31:0] corners [26] = '{
    32'h0000_0000, 32'h07FF_FFFF, 32'h0800_0000, 32'h0800_7FFF, 32'h0800_8000,
    32'h0BFF_FFFF, 32'h0C00_0000, 32'h0C00_1FFF, 32'h0C00_2000, 32'h0FFF_FFFF,
    32'h1000_0000, 32'h17FF_FFFF, 32'h1800_0000, 32'h3800_0000, 32'h3FFF_FFFF,
    32'h4000_0000, 32'h4FFF_FFFF, 32'h5000_0000, 32'h5FFF_FFFF, 32'h6000_0000,
    32'h6FFF_FFFF, 32'h7000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
    32'h0000_A123
  };

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    // R10: reset clears every output
    compare("R10", pack_out(got_sel(), via_mirror, dec_err, offset), '0);
    rst = 1'b0;

    // R6 / R7: boot window under every boot mode
    for (int m = 0; m < 4; m++) begin
      apply(32'h0000_0000, 2'(m));
      apply(32'h07FF_FFFF, 2'(m));
      apply(32'h0000_A123, 2'(m));
    end

    // R1..R5, R8: window edges and alias points
    for (int i = 0; i < 26; i++) apply(corners[i], 2'($urandom_range(0, 3)));

    // R10: reset in mid-run clears registered outputs
    addr = 32'h5000_0040; boot_mode = 2'b00; rst = 1'b1;
    @(negedge clk);
    compare("R10", pack_out(got_sel(), via_mirror, dec_err, offset), '0);
    rst = 1'b0;
    prev_exp = '0;

    // random stimulus across all regions
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      case ($urandom_range(0, 8))
        0: a = $urandom() & 32'h07FF_FFFF;
        1: a = 32'h0800_0000 | ($urandom() & 32'h03FF_FFFF);
        2: a = 32'h0C00_0000 | ($urandom() & 32'h03FF_FFFF);
        3: a = 32'h1000_0000 + $urandom_range(0, 32'h2FFF_FFFF);
        4: a = 32'h4000_0000 | ($urandom() & 32'h0FFF_FFFF);
        5: a = 32'h5000_0000 + $urandom_range(0, 32'h1FFF_FFFF);
        6: a = 32'h7000_0000 + $urandom_range(0, 32'h0FFF_FFFF);
        default: a = $urandom();
      endcase
      apply(a, 2'($urandom_range(0, 3)));
    end
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired got=running exp=finished");
      finish_run();
    end
  end
endmodule